// File: doc/BRIEF.md
# Timer Output Compare Channel

One output-compare channel of a general-purpose timer. The timer supplies its counter value, its count direction, a one-cycle update strobe and an external clear level. The channel holds a compare value, optionally staged behind a shadow register, and a control word that selects one of eight reference behaviours, the preload option, the external-clear option and two output polarities. It registers an active-high reference level once per clock and derives a main and a complementary output from it.

Software, or the surrounding timer logic, writes the two registers through a write-enable, one-bit address and data port. The same address on a separate read select returns the control word or the compare value that software sees. A lock-level input from the timer freezes the mode field while the channel is set up as an output.

Top module: `tmr_oc_channel`

## Requirements
- R1: After synchronous reset, the control word, the shadow and active compare values and the reference are all 0, so the main output is 0 and the complementary output is 1.
- R2: In mode 000 (freeze) the reference holds its value whatever the counter does.
- R3: Mode 001 sets the reference to 1, mode 010 clears it to 0 and mode 011 inverts it, in the clock edge at which the counter equals the active compare value; with no equality it holds.
- R4: Mode 100 drives the reference to 0 and mode 101 drives it to 1 at every edge, independent of the counter.
- R5: Mode 110, counting up (direction input 0): the reference goes to 1 when the counter is less than or equal to the compare value and to 0 when greater; counting down (direction input 1): 1 when greater, 0 otherwise.
- R6: Mode 111 gives the inverse of the mode 110 level in both directions.
- R7: In modes 110 and 111 the reference only takes the new level on an edge where the comparison result differs from the previous cycle, or where the mode in the previous cycle was 000; otherwise it holds, even if it disagrees with the level.
- R8: With the clear-enable bit set, a high external clear drives the reference to 0 at every edge, overriding all modes; afterwards the mode acts again from the next comparison event. With the bit at 0, the external clear has no effect.
- R9: With preload enabled, a write to address 1 goes to the shadow only, a read of address 1 returns the shadow, and the shadow is copied into the active compare value at the edge where the update strobe is high.
- R10: With preload disabled, a write to address 1 loads the active compare value (and the shadow) at the write edge; a read returns the active value.
- R11: The main output is the reference XOR the main polarity bit; the complementary output is the inverted reference XOR the complementary polarity bit.
- R12: While the lock-level input is 3 and the direction field is 00 (output), writes to the control word leave the mode field unchanged; all other fields are written.
- R13: Address 0 is the control word, read back zero-extended: bits [1:0] direction (00 = output), bit 2 preload enable, bits [5:3] mode, bit 6 clear enable, bit 7 main polarity, bit 8 complementary polarity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_val | input | CW | Timer counter value |
| cnt_down | input | 1 | Count direction, 1 = counting down |
| upd_evt | input | 1 | Update event strobe |
| ext_clr | input | 1 | External clear level |
| lock_lvl | input | 2 | Timer write-lock level |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 1 | Write address, 0 control, 1 compare |
| wr_data | input | CW | Write data |
| rd_addr | input | 1 | Read select, 0 control, 1 compare |
| rd_data | output | CW | Read data |
| oc_ref | output | 1 | Active-high reference level |
| oc_main | output | 1 | Polarity-adjusted main output |
| oc_comp | output | 1 | Polarity-adjusted complementary output |

## Verification
On every cycle the assertions check that the forced modes and an enabled external clear set the reference in the following edge, that freeze holds it, that a set-on-match equality raises it, that the update strobe moves the shadow into the active compare value, that a locked mode field never changes, and that equal polarities keep the two outputs opposite. The direction-aware PWM levels, the hold-until-the-comparison-changes rule, the freeze-to-PWM reload, clear release behaviour and the read-back view under each preload setting depend on sequences of counter values, so only the bench's directed scenarios show them.

// File: rtl/tmr_oc_pkg.sv
package tmr_oc_pkg;

    typedef enum logic [2:0] {
        OCM_FREEZE = 3'b000,
        OCM_SET    = 3'b001,
        OCM_CLR    = 3'b010,
        OCM_TOG    = 3'b011,
        OCM_LO     = 3'b100,
        OCM_HI     = 3'b101,
        OCM_PWM1   = 3'b110,
        OCM_PWM2   = 3'b111
    } ocm_e;

    // Packed MSB first: direction lands in bits [1:0].
    typedef struct packed {
        logic       pol_comp;
        logic       pol_main;
        logic       clr_en;
        ocm_e       mode;
        logic       pre_en;
        logic [1:0] dir;
    } oc_ctrl_t;

    localparam int         CTRL_W    = $bits(oc_ctrl_t);
    localparam logic       ADDR_CTRL = 1'b0;
    localparam logic       ADDR_CMP  = 1'b1;
    localparam logic [1:0] DIR_OUT   = 2'b00;
    localparam logic [1:0] LOCK_FULL = 2'd3;

    function automatic logic is_pwm(input ocm_e m);
        return (m == OCM_PWM1) || (m == OCM_PWM2);
    endfunction

    // Apply a control write, keeping the mode when it is locked.
    function automatic oc_ctrl_t merge_ctrl(input oc_ctrl_t cur,
                                            input oc_ctrl_t req,
                                            input logic     mode_locked);
        oc_ctrl_t res;
        res = req;
        if (mode_locked) res.mode = cur.mode;
        return res;
    endfunction

endpackage

// File: rtl/tmr_oc_regs.sv
module tmr_oc_regs
    import tmr_oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          upd_evt,
    input  logic [1:0]    lock_lvl,
    input  logic          rd_addr,
    output oc_ctrl_t      ctrl,
    output logic [CW-1:0] cmp_shadow,
    output logic [CW-1:0] cmp_act,
    output logic [CW-1:0] rd_data
);

    logic mode_locked;
    logic wr_ctrl, wr_cmp;

    assign mode_locked = (lock_lvl == LOCK_FULL) && (ctrl.dir == DIR_OUT);
    assign wr_ctrl     = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_cmp      = wr_en && (wr_addr == ADDR_CMP);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl <= merge_ctrl(ctrl, oc_ctrl_t'(wr_data[CTRL_W-1:0]), mode_locked);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_shadow <= '0;
            cmp_act    <= '0;
        end else begin
            if (wr_cmp) cmp_shadow <= wr_data;
            if (ctrl.pre_en) begin
                if (upd_evt) cmp_act <= cmp_shadow;
            end else if (wr_cmp) begin
                cmp_act <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) rd_data[CTRL_W-1:0] = ctrl;
        else if (ctrl.pre_en)     rd_data = cmp_shadow;
        else                      rd_data = cmp_act;
    end

endmodule

// File: rtl/tmr_oc_cmp.sv
module tmr_oc_cmp #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_down,
    input  logic [CW-1:0] cmp_act,
    output logic          match,
    output logic          pwm_act,
    output logic          cmp_edge
);

    logic above;
    logic pwm_prev;

    assign match   = (cnt_val == cmp_act);
    assign above   = (cnt_val > cmp_act);
    // Level of the first PWM mode; the second mode inverts it later.
    assign pwm_act = cnt_down ? above : !above;

    always_ff @(posedge clk) begin
        if (rst) pwm_prev <= 1'b0;
        else     pwm_prev <= pwm_act;
    end

    assign cmp_edge = (pwm_act != pwm_prev);

endmodule

// File: rtl/tmr_oc_refgen.sv
module tmr_oc_refgen
    import tmr_oc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  ocm_e mode,
    input  logic clr_en,
    input  logic ext_clr,
    input  logic match,
    input  logic pwm_act,
    input  logic cmp_edge,
    output logic oc_ref
);

    ocm_e mode_prev;
    logic pwm_lvl;
    logic pwm_load;

    assign pwm_lvl  = (mode == OCM_PWM1) ? pwm_act : !pwm_act;
    assign pwm_load = cmp_edge || (mode_prev == OCM_FREEZE);

    always_ff @(posedge clk) begin
        if (rst) begin
            oc_ref    <= 1'b0;
            mode_prev <= OCM_FREEZE;
        end else begin
            mode_prev <= mode;
            if (clr_en && ext_clr) begin
                oc_ref <= 1'b0;
            end else begin
                unique case (mode)
                    OCM_FREEZE: oc_ref <= oc_ref;
                    OCM_SET:    if (match) oc_ref <= 1'b1;
                    OCM_CLR:    if (match) oc_ref <= 1'b0;
                    OCM_TOG:    if (match) oc_ref <= !oc_ref;
                    OCM_LO:     oc_ref <= 1'b0;
                    OCM_HI:     oc_ref <= 1'b1;
                    default:    if (is_pwm(mode) && pwm_load) oc_ref <= pwm_lvl;
                endcase
            end
        end
    end

endmodule

// File: rtl/tmr_oc_channel.sv
module tmr_oc_channel
    import tmr_oc_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CW-1:0] cnt_val,
    input  logic          cnt_down,
    input  logic          upd_evt,
    input  logic          ext_clr,
    input  logic [1:0]    lock_lvl,
    input  logic          wr_en,
    input  logic          wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          rd_addr,
    output logic [CW-1:0] rd_data,
    output logic          oc_ref,
    output logic          oc_main,
    output logic          oc_comp
);

    oc_ctrl_t      ctrl_q;
    logic [CW-1:0] cmp_shadow;
    logic [CW-1:0] cmp_act;
    logic          match_w;
    logic          pwm_act_w;
    logic          cmp_edge_w;

    tmr_oc_regs #(.CW(CW)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .upd_evt    (upd_evt),
        .lock_lvl   (lock_lvl),
        .rd_addr    (rd_addr),
        .ctrl       (ctrl_q),
        .cmp_shadow (cmp_shadow),
        .cmp_act    (cmp_act),
        .rd_data    (rd_data)
    );

    tmr_oc_cmp #(.CW(CW)) u_cmp (
        .clk      (clk),
        .rst      (rst),
        .cnt_val  (cnt_val),
        .cnt_down (cnt_down),
        .cmp_act  (cmp_act),
        .match    (match_w),
        .pwm_act  (pwm_act_w),
        .cmp_edge (cmp_edge_w)
    );

    tmr_oc_refgen u_ref (
        .clk      (clk),
        .rst      (rst),
        .mode     (ctrl_q.mode),
        .clr_en   (ctrl_q.clr_en),
        .ext_clr  (ext_clr),
        .match    (match_w),
        .pwm_act  (pwm_act_w),
        .cmp_edge (cmp_edge_w),
        .oc_ref   (oc_ref)
    );

    assign oc_main = oc_ref ^ ctrl_q.pol_main;
    assign oc_comp = !oc_ref ^ ctrl_q.pol_comp;

endmodule

// File: rtl/tmr_oc_channel_chk.sv
module tmr_oc_channel_chk
    import tmr_oc_pkg::*;
#(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          ext_clr,
    input logic          upd_evt,
    input logic [1:0]    lock_lvl,
    input oc_ctrl_t      ctrl,
    input logic [CW-1:0] cmp_shadow,
    input logic [CW-1:0] cmp_act,
    input logic          match,
    input logic          oc_ref,
    input logic          oc_main,
    input logic          oc_comp
);

    logic clr_on;
    assign clr_on = ctrl.clr_en && ext_clr;

    p_freeze_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == OCM_FREEZE && !clr_on) |=> $stable(oc_ref));

    p_set_on_match_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == OCM_SET && match && !clr_on) |=> oc_ref);

    p_force_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == OCM_LO) |=> !oc_ref);

    p_force_hi_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl.mode == OCM_HI && !clr_on) |=> oc_ref);

    p_ext_clear_r8: assert property (@(posedge clk) disable iff (rst)
        clr_on |=> !oc_ref);

    p_preload_xfer_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pre_en && upd_evt) |=> (cmp_act == $past(cmp_shadow)));

    p_outputs_opposite_r11: assert property (@(posedge clk) disable iff (rst)
        (ctrl.pol_main == ctrl.pol_comp) |-> (oc_main != oc_comp));

    p_mode_locked_r12: assert property (@(posedge clk) disable iff (rst)
        (lock_lvl == LOCK_FULL && ctrl.dir == DIR_OUT) |=> (ctrl.mode == $past(ctrl.mode)));

endmodule

bind tmr_oc_channel tmr_oc_channel_chk #(.CW(CW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ext_clr    (ext_clr),
    .upd_evt    (upd_evt),
    .lock_lvl   (lock_lvl),
    .ctrl       (ctrl_q),
    .cmp_shadow (cmp_shadow),
    .cmp_act    (cmp_act),
    .match      (match_w),
    .oc_ref     (oc_ref),
    .oc_main    (oc_main),
    .oc_comp    (oc_comp)
);

// File: tb/tmr_oc_channel_tb.sv
`timescale 1ns/1ps
module tmr_oc_channel_tb;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] cnt_val;
    logic          cnt_down;
    logic          upd_evt;
    logic          ext_clr;
    logic [1:0]    lock_lvl;
    logic          wr_en;
    logic          wr_addr;
    logic [CW-1:0] wr_data;
    logic          rd_addr;
    logic [CW-1:0] rd_data;
    logic          oc_ref, oc_main, oc_comp;

    int n_checks = 0;
    int n_errors = 0;
    bit done     = 1'b0;

    always #2.5 clk = !clk;

    tmr_oc_channel #(.CW(CW)) u_dut (
        .clk(clk), .rst(rst), .cnt_val(cnt_val), .cnt_down(cnt_down),
        .upd_evt(upd_evt), .ext_clr(ext_clr), .lock_lvl(lock_lvl),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .oc_ref(oc_ref), .oc_main(oc_main), .oc_comp(oc_comp)
    );

    // Control word per R13.
    function automatic logic [CW-1:0] cw(input logic [1:0] dir, input logic pre,
                                         input logic [2:0] mode, input logic clr,
                                         input logic pm, input logic pc);
        logic [CW-1:0] v;
        v = '0;
        v[8:0] = {pc, pm, clr, mode, pre, dir};
        return v;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_ref(input logic exp, input string req);
        check(oc_ref === exp, req, int'(oc_ref), int'(exp));
    endtask

    task automatic wr(input logic a, input logic [CW-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic a, input logic [CW-1:0] exp, input string req);
        rd_addr = a;
        #0.5;
        check(rd_data === exp, req, int'(rd_data), int'(exp));
    endtask

    task automatic t_reset();
        chk_ref(1'b0, "R1 ref");
        check(oc_main === 1'b0, "R1 main", int'(oc_main), 0);
        check(oc_comp === 1'b1, "R1 comp", int'(oc_comp), 1);
        chk_rd(1'b0, '0, "R1 ctrl read");
        chk_rd(1'b1, '0, "R1 compare read");
    endtask

    task automatic t_force();
        wr(1'b0, cw(2'b00, 0, 3'b101, 0, 0, 0));
        chk_rd(1'b0, 16'h0028, "R13 ctrl layout");
        tick();
        chk_ref(1'b1, "R4 force high");
        wr(1'b0, cw(2'b00, 0, 3'b100, 0, 0, 0));
        tick();
        chk_ref(1'b0, "R4 force low");
    endtask

    task automatic t_freeze();
        wr(1'b0, cw(2'b00, 0, 3'b101, 0, 0, 0));
        tick();
        wr(1'b0, cw(2'b00, 0, 3'b000, 0, 0, 0));
        for (int i = 0; i < 4; i++) begin
            cnt_val = 16'(i);
            tick();
        end
        chk_ref(1'b1, "R2 freeze holds");
    endtask

    task automatic t_match();
        wr(1'b1, 16'd10);
        wr(1'b0, cw(2'b00, 0, 3'b100, 0, 0, 0));
        cnt_val = 16'd5;
        wr(1'b0, cw(2'b00, 0, 3'b001, 0, 0, 0));
        tick();
        chk_ref(1'b0, "R3 set without match");
        cnt_val = 16'd10; tick();
        chk_ref(1'b1, "R3 set on match");
        cnt_val = 16'd5;
        wr(1'b0, cw(2'b00, 0, 3'b010, 0, 0, 0));
        tick();
        chk_ref(1'b1, "R3 clear without match");
        cnt_val = 16'd10; tick();
        chk_ref(1'b0, "R3 clear on match");
        cnt_val = 16'd5;
        wr(1'b0, cw(2'b00, 0, 3'b011, 0, 0, 0));
        cnt_val = 16'd10; tick();
        chk_ref(1'b1, "R3 toggle up");
        cnt_val = 16'd11; tick();
        chk_ref(1'b1, "R3 toggle hold");
        cnt_val = 16'd10; tick();
        chk_ref(1'b0, "R3 toggle down");
    endtask

    task automatic t_pwm1();
        cnt_down = 1'b0; cnt_val = 16'd5;
        wr(1'b0, cw(2'b00, 0, 3'b000, 0, 0, 0));
        wr(1'b0, cw(2'b00, 0, 3'b110, 0, 0, 0));
        tick();
        chk_ref(1'b1, "R5 up below, loaded from freeze");
        cnt_val = 16'd11; tick();
        chk_ref(1'b0, "R5 up above");
        cnt_val = 16'd10; tick();
        chk_ref(1'b1, "R5 up equal");
        cnt_down = 1'b1; cnt_val = 16'd11; tick();
        chk_ref(1'b1, "R5 down above");
        cnt_val = 16'd10; tick();
        chk_ref(1'b0, "R5 down equal");
        cnt_val = 16'd15; tick();
        chk_ref(1'b1, "R5 down above again");
    endtask

    task automatic t_pwm2();
        cnt_down = 1'b0; cnt_val = 16'd5;
        wr(1'b0, cw(2'b00, 0, 3'b000, 0, 0, 0));
        wr(1'b0, cw(2'b00, 0, 3'b111, 0, 0, 0));
        tick();
        chk_ref(1'b0, "R6 up below");
        cnt_val = 16'd12; tick();
        chk_ref(1'b1, "R6 up above");
        cnt_down = 1'b1; tick();
        chk_ref(1'b0, "R6 down above");
        cnt_val = 16'd4; tick();
        chk_ref(1'b1, "R6 down below");
    endtask

    task automatic t_pwm_hold();
        cnt_down = 1'b0; cnt_val = 16'd12;
        wr(1'b0, cw(2'b00, 0, 3'b101, 0, 0, 0));
        tick();
        wr(1'b0, cw(2'b00, 0, 3'b110, 0, 0, 0));
        tick(); tick();
        chk_ref(1'b1, "R7 holds without comparison change");
        cnt_val = 16'd5; tick();
        cnt_val = 16'd12; tick();
        chk_ref(1'b0, "R7 follows comparison change");
    endtask

    task automatic t_clear();
        wr(1'b0, cw(2'b00, 0, 3'b101, 0, 0, 0));
        tick();
        ext_clr = 1'b1; tick();
        chk_ref(1'b1, "R8 clear ignored when disabled");
        wr(1'b0, cw(2'b00, 0, 3'b101, 1, 0, 0));
        tick();
        chk_ref(1'b0, "R8 clear overrides force high");
        ext_clr = 1'b0; tick();
        chk_ref(1'b1, "R8 force high after release");
        ext_clr = 1'b1; cnt_val = 16'd10;
        wr(1'b0, cw(2'b00, 0, 3'b001, 1, 0, 0));
        tick();
        chk_ref(1'b0, "R8 clear beats match");
        ext_clr = 1'b0; cnt_val = 16'd3; tick();
        chk_ref(1'b0, "R8 released, no event");
        cnt_val = 16'd10; tick();
        chk_ref(1'b1, "R8 next match acts");
    endtask

    task automatic t_preload();
        cnt_val = 16'd0;
        wr(1'b0, cw(2'b00, 0, 3'b100, 0, 0, 0));
        wr(1'b1, 16'd20);
        chk_rd(1'b1, 16'd20, "R10 read active");
        wr(1'b0, cw(2'b00, 1, 3'b001, 0, 0, 0));
        wr(1'b1, 16'd30);
        chk_rd(1'b1, 16'd30, "R9 read shadow");
        cnt_val = 16'd30; tick();
        chk_ref(1'b0, "R9 shadow not yet active");
        cnt_val = 16'd20; tick();
        chk_ref(1'b1, "R9 old value still active");
        cnt_val = 16'd0;
        wr(1'b0, cw(2'b00, 1, 3'b100, 0, 0, 0));
        wr(1'b0, cw(2'b00, 1, 3'b001, 0, 0, 0));
        upd_evt = 1'b1; tick();
        upd_evt = 1'b0;
        chk_ref(1'b0, "R9 no match during update");
        cnt_val = 16'd30; tick();
        chk_ref(1'b1, "R9 transferred on update");
        cnt_val = 16'd0;
        wr(1'b0, cw(2'b00, 0, 3'b010, 0, 0, 0));
        wr(1'b1, 16'd7);
        cnt_val = 16'd7; tick();
        chk_ref(1'b0, "R10 immediate compare");
    endtask

    task automatic t_polarity();
        wr(1'b0, cw(2'b00, 0, 3'b101, 0, 0, 0));
        tick();
        check(oc_main === 1'b1, "R11 main pol0", int'(oc_main), 1);
        check(oc_comp === 1'b0, "R11 comp pol0", int'(oc_comp), 0);
        wr(1'b0, cw(2'b00, 0, 3'b101, 0, 1, 1));
        check(oc_main === 1'b0, "R11 main pol1", int'(oc_main), 0);
        check(oc_comp === 1'b1, "R11 comp pol1", int'(oc_comp), 1);
        wr(1'b0, cw(2'b00, 0, 3'b100, 0, 1, 0));
        tick();
        check(oc_main === 1'b1, "R11 main low ref", int'(oc_main), 1);
        check(oc_comp === 1'b1, "R11 comp low ref", int'(oc_comp), 1);
    endtask

    task automatic t_lock();
        wr(1'b0, cw(2'b00, 0, 3'b101, 0, 0, 0));
        tick();
        lock_lvl = 2'd3;
        wr(1'b0, cw(2'b00, 0, 3'b100, 0, 1, 0));
        tick();
        chk_ref(1'b1, "R12 mode locked");
        chk_rd(1'b0, cw(2'b00, 0, 3'b101, 0, 1, 0), "R12 other fields written");
        wr(1'b0, cw(2'b01, 0, 3'b101, 0, 0, 0));
        wr(1'b0, cw(2'b01, 0, 3'b100, 0, 0, 0));
        chk_rd(1'b0, cw(2'b01, 0, 3'b100, 0, 0, 0), "R12 unlocked when not output");
        lock_lvl = 2'd2;
        wr(1'b0, cw(2'b00, 0, 3'b101, 0, 0, 0));
        wr(1'b0, cw(2'b00, 0, 3'b000, 0, 0, 0));
        chk_rd(1'b0, cw(2'b00, 0, 3'b000, 0, 0, 0), "R12 level 2 writable");
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    initial begin
        rst = 1'b1; cnt_val = '0; cnt_down = 1'b0; upd_evt = 1'b0;
        ext_clr = 1'b0; lock_lvl = 2'd0; wr_en = 1'b0; wr_addr = 1'b0;
        wr_data = '0; rd_addr = 1'b0;
        repeat (3) tick();
        rst = 1'b0;
        t_reset();
        t_force();
        t_freeze();
        t_match();
        t_pwm1();
        t_pwm2();
        t_pwm_hold();
        t_clear();
        t_preload();
        t_polarity();
        t_lock();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            report();
        end
    end

endmodule